// File: doc/BRIEF.md
# Eight-bit Accumulator ALU with Status Flags

This block is the combinational arithmetic and logic unit of a small accumulator-style microcontroller core. On every evaluation it takes an operation code, two 8-bit operands and the current carry and nibble-carry flags. It returns an 8-bit result, new carry, nibble-carry, zero and overflow values, and a per-flag update mask that tells the flag storage outside the block which flags to load. It also returns a skip decision that the sequencer uses for the conditional-skip instructions.

Subtraction follows the "carry means no borrow" convention, so the carry feeds straight into subtract-with-borrow for multi-byte arithmetic. A decimal-adjust operation corrects a packed-BCD sum using the carry and nibble-carry flags. Decode, the register file, the program counter and the flag registers sit outside the block.

Top module: `alu8_core`

## Requirements
- R1: Operation codes come from the package enumeration `alu_op_e` (ADD=0, ADC=1, SUB=2, SBC=3, DAA=4, AND=5, OR=6, XOR=7, CPL=8, RL=9, RR=10, RLC=11, RRC=12, INC=13, DEC=14, SZ=15, SNZ=16, SIZ=17, SDZ=18). ADD returns a+b and ADC returns a+b+c_i, each modulo 256, and carry out is set when the true sum exceeds 255.
- R2: SUB returns a-b and SBC returns a-b-(1-c_i), each modulo 256. Carry out is 1 when no borrow occurs and 0 when one does.
- R3: For ADD, ADC, SUB and SBC, ac_o is the carry out of bit 3 of the internal addition. For subtraction this is 1 when the low nibble does not borrow.
- R4: For ADD, ADC, SUB and SBC, ov_o is set exactly when the signed two's-complement result does not fit in 8 bits. This is the case where the carry into bit 7 differs from the carry out of bit 7.
- R5: Whenever the zero flag is in the update mask, z_o is 1 exactly when res_o is 0x00.
- R6: DAA works on operand a. It first adds 0x06 if the low nibble exceeds 9 or ac_i is 1. It then adds 0x60 if that intermediate value exceeds 0xFF, its high nibble exceeds 9, or c_i is 1. In that last case c_o is 1; otherwise c_o equals c_i. It updates C and Z.
- R7: AND, OR and XOR return the bitwise combination of a and b. CPL returns the bitwise inverse of a. All four update only Z.
- R8: RL and RR rotate a left or right by one inside the 8 bits and update no flag. RLC and RRC rotate a through the carry: the incoming c_i enters the vacated bit, the bit shifted out becomes c_o, and only C is updated.
- R9: INC returns a+1 and DEC returns a-1, modulo 256, and both update only Z.
- R10: SZ passes a through and asserts skip when a is 0x00. SNZ passes a through and asserts skip when a is not 0x00. Neither updates a flag.
- R11: SIZ returns a+1 and SDZ returns a-1, modulo 256. Each asserts skip when that new value is 0x00, and neither updates a flag.
- R12: upd_o carries one bit per flag at the position the status register uses: bit 0 C, bit 1 AC, bit 2 Z, bit 3 OV. ADD, ADC, SUB and SBC set all four bits. Any flag output whose mask bit is 0 is driven 0.
- R13: skip_o is 0 for every operation other than SZ, SNZ, SIZ and SDZ. Codes 19 to 31 return result 0x00, mask 0 and no skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code (alu_op_e value) |
| a_i | input | 8 | First operand (accumulator side) |
| b_i | input | 8 | Second operand |
| c_i | input | 1 | Current carry flag |
| ac_i | input | 1 | Current nibble-carry flag |
| res_o | output | 8 | Operation result |
| c_o | output | 1 | New carry value |
| ac_o | output | 1 | New nibble-carry value |
| z_o | output | 1 | New zero value |
| ov_o | output | 1 | New overflow value |
| upd_o | output | 4 | Flag update mask {OV,Z,AC,C} |
| skip_o | output | 1 | Skip the next instruction |

## Verification
The hardest outcomes to reach are in decimal adjust. Only a few operand and flag combinations drive the intermediate value past 0xFF, or add the high correction when the high nibble is in range only because the incoming carry is set. The same holds for results that a plain BCD sum cannot produce. The stimulus walks every operand value for DAA under all four combinations of c_i and ac_i. It also aims directed vectors at the signed-overflow edges (0x7F+1, 0x80-1), the nibble boundary, SBC chained over two bytes, and SIZ/SDZ at the wrap values. A large random sweep over all 32 codes follows, and a behavioural model in the bench checks every vector.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DW    = 8;
    localparam int NIBW  = 4;
    localparam int OPW   = 5;
    localparam int FLAGS = 4;
    localparam logic [NIBW-1:0] BCD_MAX = NIBW'(9);
    localparam logic [DW-1:0]   LO_FIX  = DW'(6);
    localparam logic [DW-1:0]   HI_FIX  = DW'(6) << NIBW;

    typedef enum logic [OPW-1:0] {
        OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
        OP_DAA = 5'd4,  OP_AND = 5'd5,  OP_OR  = 5'd6,  OP_XOR = 5'd7,
        OP_CPL = 5'd8,  OP_RL  = 5'd9,  OP_RR  = 5'd10, OP_RLC = 5'd11,
        OP_RRC = 5'd12, OP_INC = 5'd13, OP_DEC = 5'd14, OP_SZ  = 5'd15,
        OP_SNZ = 5'd16, OP_SIZ = 5'd17, OP_SDZ = 5'd18
    } alu_op_e;

    // bit order matches the status register: c at bit 0, ov at bit 3
    typedef struct packed {
        logic ov;
        logic z;
        logic ac;
        logic c;
    } flag_t;

    localparam logic [FLAGS-1:0] UPD_NONE = 4'b0000;
    localparam logic [FLAGS-1:0] UPD_C    = 4'b0001;
    localparam logic [FLAGS-1:0] UPD_Z    = 4'b0100;
    localparam logic [FLAGS-1:0] UPD_CZ   = 4'b0101;
    localparam logic [FLAGS-1:0] UPD_ALL  = 4'b1111;

    function automatic logic is_zero(input logic [DW-1:0] v);
        return (v == '0);
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
#(
    parameter int W  = DW,
    parameter int NB = NIBW
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         ci_i,
    output logic [W-1:0] sum_o,
    output logic         co_o,
    output logic         nco_o,
    output logic         cmsb_o
);
    localparam int NSEG = W / NB;

    logic [NSEG:0] cy;
    assign cy[0] = ci_i;

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        logic [NB:0] seg;
        assign seg = {1'b0, x_i[g*NB +: NB]} + {1'b0, y_i[g*NB +: NB]}
                   + {{NB{1'b0}}, cy[g]};
        assign sum_o[g*NB +: NB] = seg[NB-1:0];
        assign cy[g+1]           = seg[NB];
    end

    assign co_o   = cy[NSEG];
    assign nco_o  = cy[1];
    assign cmsb_o = sum_o[W-1] ^ x_i[W-1] ^ y_i[W-1];

    always_comb begin
        if (!$isunknown({x_i, y_i, ci_i})) begin
            // R1: segmented chain agrees with a full-width sum
            a_r1_chain_sum: assert ({co_o, sum_o} ==
                ({1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, ci_i}));
        end
    end

endmodule

// File: rtl/alu8_shift_logic.sv
module alu8_shift_logic
    import alu8_pkg::*;
#(
    parameter int W = DW
) (
    input  alu_op_e      op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         ci_i,
    output logic [W-1:0] res_o,
    output logic         co_o
);
    always_comb begin
        res_o = '0;
        co_o  = 1'b0;
        unique case (op_i)
            OP_AND: res_o = a_i & b_i;
            OP_OR:  res_o = a_i | b_i;
            OP_XOR: res_o = a_i ^ b_i;
            OP_CPL: res_o = ~a_i;
            OP_RL:  res_o = {a_i[W-2:0], a_i[W-1]};
            OP_RR:  res_o = {a_i[0], a_i[W-1:1]};
            OP_RLC: begin
                res_o = {a_i[W-2:0], ci_i};
                co_o  = a_i[W-1];
            end
            OP_RRC: begin
                res_o = {ci_i, a_i[W-1:1]};
                co_o  = a_i[0];
            end
            default: ;
        endcase
    end

    always_comb begin
        if (!$isunknown({op_i, a_i, ci_i})) begin
            // R8: plain rotates keep every bit of the operand
            a_r8_rot_popcount: assert (!(op_i == OP_RL || op_i == OP_RR) ||
                ($countones(res_o) == $countones(a_i)));
        end
    end

endmodule

// File: rtl/alu8_decadj.sv
module alu8_decadj
    import alu8_pkg::*;
#(
    parameter int W  = DW,
    parameter int NB = NIBW
) (
    input  logic [W-1:0] a_i,
    input  logic         ci_i,
    input  logic         aci_i,
    output logic [W-1:0] res_o,
    output logic         co_o
);
    logic [W:0] stage1;
    logic       lo_fix, hi_fix;

    always_comb begin
        lo_fix = (a_i[NB-1:0] > BCD_MAX) || aci_i;
        stage1 = {1'b0, a_i} + (lo_fix ? {1'b0, LO_FIX} : '0);
        hi_fix = stage1[W] || (stage1[W-1:NB] > BCD_MAX) || ci_i;
        res_o  = stage1[W-1:0] + (hi_fix ? HI_FIX : '0);
        co_o   = hi_fix;
    end

    always_comb begin
        if (!$isunknown({a_i, ci_i, aci_i})) begin
            // R6: a decimal carry is never lost
            a_r6_carry_kept: assert (!ci_i || co_o);
        end
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic [OPW-1:0]   op_i,
    input  logic [DW-1:0]    a_i,
    input  logic [DW-1:0]    b_i,
    input  logic             c_i,
    input  logic             ac_i,
    output logic [DW-1:0]    res_o,
    output logic             c_o,
    output logic             ac_o,
    output logic             z_o,
    output logic             ov_o,
    output logic [FLAGS-1:0] upd_o,
    output logic             skip_o
);
    alu_op_e op;
    assign op = alu_op_e'(op_i);

    logic [DW-1:0] add_x, add_y, add_sum;
    logic          add_ci, add_co, add_nco, add_cmsb;
    logic [DW-1:0] sl_res, daa_res;
    logic          sl_co, daa_co;
    flag_t         fl;

    always_comb begin
        add_x  = a_i;
        add_y  = b_i;
        add_ci = 1'b0;
        unique case (op)
            OP_ADC: add_ci = c_i;
            OP_SUB: begin add_y = ~b_i; add_ci = 1'b1; end
            OP_SBC: begin add_y = ~b_i; add_ci = c_i;  end
            OP_INC, OP_SIZ: begin add_y = '0; add_ci = 1'b1; end
            OP_DEC, OP_SDZ: begin add_y = '1; add_ci = 1'b0; end
            default: ;
        endcase
    end

    alu8_addsub #(.W(DW), .NB(NIBW)) u_addsub (
        .x_i(add_x), .y_i(add_y), .ci_i(add_ci),
        .sum_o(add_sum), .co_o(add_co), .nco_o(add_nco), .cmsb_o(add_cmsb)
    );

    alu8_shift_logic #(.W(DW)) u_shl (
        .op_i(op), .a_i(a_i), .b_i(b_i), .ci_i(c_i),
        .res_o(sl_res), .co_o(sl_co)
    );

    alu8_decadj #(.W(DW), .NB(NIBW)) u_daa (
        .a_i(a_i), .ci_i(c_i), .aci_i(ac_i),
        .res_o(daa_res), .co_o(daa_co)
    );

    always_comb begin
        res_o  = '0;
        fl     = '0;
        upd_o  = UPD_NONE;
        skip_o = 1'b0;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
                res_o = add_sum;
                fl.c  = add_co;
                fl.ac = add_nco;
                fl.ov = add_cmsb ^ add_co;
                fl.z  = is_zero(add_sum);
                upd_o = UPD_ALL;
            end
            OP_DAA: begin
                res_o = daa_res;
                fl.c  = daa_co;
                fl.z  = is_zero(daa_res);
                upd_o = UPD_CZ;
            end
            OP_AND, OP_OR, OP_XOR, OP_CPL: begin
                res_o = sl_res;
                fl.z  = is_zero(sl_res);
                upd_o = UPD_Z;
            end
            OP_RL, OP_RR: res_o = sl_res;
            OP_RLC, OP_RRC: begin
                res_o = sl_res;
                fl.c  = sl_co;
                upd_o = UPD_C;
            end
            OP_INC, OP_DEC: begin
                res_o = add_sum;
                fl.z  = is_zero(add_sum);
                upd_o = UPD_Z;
            end
            OP_SIZ, OP_SDZ: begin
                res_o  = add_sum;
                skip_o = is_zero(add_sum);
            end
            OP_SZ: begin
                res_o  = a_i;
                skip_o = is_zero(a_i);
            end
            OP_SNZ: begin
                res_o  = a_i;
                skip_o = !is_zero(a_i);
            end
            default: ;
        endcase
    end

    assign c_o  = fl.c;
    assign ac_o = fl.ac;
    assign z_o  = fl.z;
    assign ov_o = fl.ov;

    always_comb begin
        if (!$isunknown({op_i, a_i, b_i, c_i, ac_i})) begin
            // R2: subtract carry is the no-borrow indication
            a_r2_sub_no_borrow: assert (op != OP_SUB || c_o == (a_i >= b_i));
            // R5: zero flag tracks the result when it is loaded
            a_r5_zero_result: assert (!upd_o[2] || z_o == (res_o == '0));
            // R8: rotate-through-carry loses no bit
            a_r8_rlc_nine_bit: assert (op != OP_RLC || {c_o, res_o} == {a_i, c_i});
            // R10: skip-if-zero follows the operand
            a_r10_sz_skip: assert (op != OP_SZ || skip_o == (a_i == '0));
            // R12: flags outside the mask stay low
            a_r12_unmasked_low: assert (({ov_o, z_o, ac_o, c_o} & ~upd_o) == '0);
            // R13: skip only from the skip group
            a_r13_skip_group: assert (!skip_o || op == OP_SZ || op == OP_SNZ ||
                                      op == OP_SIZ || op == OP_SDZ);
        end
    end

endmodule

// File: tb/alu8_core_bench.sv
module alu8_core_bench;
    import alu8_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [4:0] op;
    logic [7:0] a, b, res;
    logic       ci, aci, co, aco, zo, ovo, skip;
    logic [3:0] upd;

    int checks = 0;
    int errors = 0;

    alu8_core u_alu8_core (
        .op_i(op), .a_i(a), .b_i(b), .c_i(ci), .ac_i(aci),
        .res_o(res), .c_o(co), .ac_o(aco), .z_o(zo), .ov_o(ovo),
        .upd_o(upd), .skip_o(skip)
    );

    function automatic string req_of(input int k);
        case (k)
            0, 1:       return "R1";
            2, 3:       return "R2";
            4:          return "R6";
            5, 6, 7, 8: return "R7";
            9, 10, 11, 12: return "R8";
            13, 14:     return "R9";
            15, 16:     return "R10";
            17, 18:     return "R11";
            default:    return "R13";
        endcase
    endfunction

    // behavioural reference: returns {skip, upd[3:0], ov, z, ac, c, res[7:0]}
    function automatic logic [16:0] model(input int k, input int x, input int y,
                                          input int c, input int ac);
        int r = 0, s, yy, cin, t;
        int fc = 0, fac = 0, fz = 0, fov = 0, m = 0, sk = 0;
        case (k)
            0, 1, 2, 3: begin
                yy  = (k >= 2) ? 255 - y : y;
                cin = (k == 0) ? 0 : (k == 2) ? 1 : c;
                s   = x + yy + cin;
                r   = s % 256;
                fc  = (s > 255);
                fac = ((x % 16) + (yy % 16) + cin) > 15;
                fov = (((x ^ r) & (yy ^ r)) & 128) != 0;
                fz  = (r == 0);
                m   = 15;
            end
            4: begin
                t  = x;
                fc = c;
                if ((x % 16) > 9 || ac != 0) t = t + 6;
                if (t > 255 || ((t / 16) % 16) > 9 || c != 0) begin
                    t  = t + 96;
                    fc = 1;
                end
                r = t % 256; fz = (r == 0); m = 5;
            end
            5:  begin r = x & y;   fz = (r == 0); m = 4; end
            6:  begin r = x | y;   fz = (r == 0); m = 4; end
            7:  begin r = x ^ y;   fz = (r == 0); m = 4; end
            8:  begin r = 255 - x; fz = (r == 0); m = 4; end
            9:  r = ((x * 2) % 256) + (x / 128);
            10: r = (x / 2) + (x % 2) * 128;
            11: begin r = ((x * 2) % 256) + c; fc = x / 128; m = 1; end
            12: begin r = (x / 2) + c * 128;   fc = x % 2;   m = 1; end
            13: begin r = (x + 1) % 256;   fz = (r == 0); m = 4; end
            14: begin r = (x + 255) % 256; fz = (r == 0); m = 4; end
            15: begin r = x; sk = (x == 0); end
            16: begin r = x; sk = (x != 0); end
            17: begin r = (x + 1) % 256;   sk = (r == 0); end
            18: begin r = (x + 255) % 256; sk = (r == 0); end
            default: r = 0;
        endcase
        return {sk[0], m[3:0], fov[0], fz[0], fac[0], fc[0], r[7:0]};
    endfunction

    task automatic run(input int k, input int x, input int y, input int c,
                       input int ac, input string tag);
        logic [16:0] exp_v, got;
        @(posedge clk);
        op = k[4:0]; a = x[7:0]; b = y[7:0]; ci = c[0]; aci = ac[0];
        @(negedge clk);
        exp_v = model(k, x, y, c, ac);
        got   = {skip, upd, ovo, zo, aco, co, res};
        checks++;
        if (got !== exp_v) begin
            errors++;
            $display("FAIL %s op=%0d a=%02h b=%02h c=%0d ac=%0d actual=%05h expected=%05h",
                     tag, k, x, y, c, ac, got, exp_v);
        end
    endtask

    initial begin
        #4_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        op = 5'd0; a = 8'h00; b = 8'h00; ci = 1'b0; aci = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset state: ADD of zeros gives zero result and Z (R1, R5)
        run(0, 0, 0, 0, 0, "R5");
        // R1 carry out and R4 overflow edges
        run(0, 8'hFF, 8'h01, 0, 0, "R1");
        run(0, 8'h7F, 8'h01, 0, 0, "R4");
        run(1, 8'h7F, 8'h00, 1, 0, "R4");
        run(2, 8'h80, 8'h01, 0, 0, "R4");
        // R3 nibble boundary
        run(0, 8'h0F, 8'h01, 0, 0, "R3");
        run(2, 8'h10, 8'h01, 1, 0, "R3");
        // R2 borrow and two-byte chain 0x0100 - 0x0001
        run(2, 8'h00, 8'h01, 0, 0, "R2");
        run(3, 8'h01, 8'h00, 0, 0, "R2");
        run(3, 8'h05, 8'h05, 1, 0, "R2");
        // R6 decimal adjust corners
        run(4, 8'h0A, 0, 0, 0, "R6");
        run(4, 8'h9A, 0, 0, 0, "R6");
        run(4, 8'hFA, 0, 0, 0, "R6");
        run(4, 8'h00, 0, 1, 1, "R6");
        // R8 rotates through carry, R11 wrap values, R10 skip tests
        run(11, 8'h80, 0, 0, 0, "R8");
        run(12, 8'h01, 0, 1, 0, "R8");
        run(17, 8'hFF, 0, 0, 0, "R11");
        run(18, 8'h01, 0, 0, 0, "R11");
        run(15, 8'h00, 0, 0, 0, "R10");
        run(16, 8'h00, 0, 0, 0, "R10");
        run(13, 8'hFF, 0, 1, 1, "R9");
        run(14, 8'h00, 0, 1, 1, "R9");
        run(8,  8'hFF, 0, 1, 1, "R7");
        // R6 exhaustive DAA sweep under every flag pair
        for (int f = 0; f < 4; f++)
            for (int x = 0; x < 256; x++)
                run(4, x, 0, f % 2, f / 2, "R6");
        // R12 and R13: random sweep over every code including unused ones
        for (int n = 0; n < 6000; n++) begin
            int k = $urandom_range(0, 31);
            run(k, $urandom_range(0, 255), $urandom_range(0, 255),
                $urandom_range(0, 1), $urandom_range(0, 1),
                (k > 18) ? "R13" : req_of(k));
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule